// File: doc/BRIEF.md
# Two-Stage Serial Clock Divider

This block derives the bit-rate timing of an SPI master from a fast reference clock. A 16-bit control word carries two 4-bit divider fields. The first stage divides the reference clock by a programmable integer from 1 to 16. The second stage divides those ticks by a power of two from 1 to 32768. The result is a single-cycle enable pulse, `step_o`, that the shift engine uses to move its serial clock one half-period. A registered level, `sclk_o`, flips on every pulse so that the divided rate can be seen directly on a wire.

Software works out the field values for a target bit rate. The block only applies them. It compares the fields against the values it last captured. When either field differs, it clears both counters and its outputs, so the first period under the new setting is full length. Bits of the control word outside the two fields have no effect.

Top module: `sclk_divider`

## Requirements
- R1: While rst_ni is low, step_o and sclk_o are 0, and both divider fields are taken as 0.
- R2: The first-stage field sits at ctrl_i[15:12]; with value p it yields one tick every p+1 reference cycles.
- R3: The second-stage field sits at ctrl_i[11:8]; with value q it passes one of every 2^q first-stage ticks.
- R4: With no field change, step_o is a one-cycle pulse repeating every (p+1)*2^q cycles; the first pulse after a restart appears (p+1)*2^q cycles after the restarting edge.
- R5: sclk_o inverts at exactly the clock edge on which step_o rises, and holds otherwise.
- R6: With both fields 0, step_o is high on every cycle from the first edge after reset or restart onward.
- R7: An edge at which either field differs from the captured value restarts the block: step_o and sclk_o go to 0 and both counters to 0.
- R8: When a restart falls on the edge where a pulse was due, the restart wins and no pulse is produced.
- R9: Changes to ctrl_i[7:0] have no effect on step_o or sclk_o.
- R10: The largest second-stage value, 15, gives a period of (p+1)*32768 cycles with no early wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ctrl_i | input | 16 | Control word carrying the two divider fields |
| step_o | output | 1 | One-cycle enable at the divided rate |
| sclk_o | output | 1 | Level that inverts on each step_o pulse |

## Verification
A field change and a due output pulse can land on the same clock edge. The bench provokes this by watching its own phase count. In the cycle before a pulse is due, it writes a new divider field. The reference model expects that edge to restart the divider with no pulse and sclk_o low. It then expects the first pulse a full new period later. Both outputs are compared on every cycle through that window.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;
  localparam int CTRL_W   = 16;
  localparam int FIELD_W  = 4;
  localparam int PRE_LSB  = 12;
  localparam int POST_LSB = 8;
  localparam int POST_CW  = (1 << FIELD_W) - 1;

  typedef struct packed {
    logic [FIELD_W-1:0] pre;
    logic [FIELD_W-1:0] post;
  } div_cfg_t;
endpackage

// File: rtl/sclk_cfg_watch.sv
module sclk_cfg_watch
  import sclk_div_pkg::*;
#(
  parameter int CW  = CTRL_W,
  parameter int FW  = FIELD_W,
  parameter int PRE = PRE_LSB,
  parameter int PST = POST_LSB
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] ctrl_i,
  output div_cfg_t      cfg_o,
  output logic          restart_o
);
  localparam logic [CW-1:0] FIELD_MASK =
    (CW'((1 << FW) - 1) << PRE) | (CW'((1 << FW) - 1) << PST);

  div_cfg_t cfg_d, cfg_q;
  logic     unused_bits;

  assign cfg_d.pre   = ctrl_i[PRE +: FW];
  assign cfg_d.post  = ctrl_i[PST +: FW];
  assign unused_bits = ^(ctrl_i & ~FIELD_MASK);
  assign restart_o   = (cfg_d != cfg_q);
  assign cfg_o       = cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cfg_q <= '0;
    else if (restart_o) cfg_q <= cfg_d;
  end
endmodule

// File: rtl/sclk_pre_div.sv
module sclk_pre_div
  import sclk_div_pkg::*;
#(
  parameter int FW = FIELD_W
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic [FW-1:0] limit_i,
  output logic [FW-1:0] cnt_o,
  output logic          tick_o
);
  logic [FW-1:0] cnt_q;

  assign tick_o = !restart_i && (cnt_q == limit_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (restart_i)          cnt_q <= '0;
    else if (cnt_q == limit_i)   cnt_q <= '0;
    else                         cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sclk_post_div.sv
module sclk_post_div
  import sclk_div_pkg::*;
#(
  parameter int FW = FIELD_W,
  parameter int CW = POST_CW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          restart_i,
  input  logic          tick_i,
  input  logic [FW-1:0] shift_i,
  output logic          roll_o
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] mask;

  // low shift_i bits all ones marks the last tick of a 2^shift group
  assign mask   = CW'((32'd1 << shift_i) - 32'd1);
  assign roll_o = tick_i && ((cnt_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (tick_i)    cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/sclk_divider.sv
module sclk_divider
  import sclk_div_pkg::*;
#(
  parameter int CW  = CTRL_W,
  parameter int FW  = FIELD_W,
  parameter int PRE = PRE_LSB,
  parameter int PST = POST_LSB
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [CW-1:0] ctrl_i,
  output logic          step_o,
  output logic          sclk_o
);
  localparam int PCW = (1 << FW) - 1;

  div_cfg_t      cfg;
  logic          restart;
  logic          pre_tick;
  logic          roll;
  logic [FW-1:0] pre_cnt;
  logic          step_q, sclk_q;

  sclk_cfg_watch #(.CW(CW), .FW(FW), .PRE(PRE), .PST(PST)) i_watch (
    .clk_i, .rst_ni, .ctrl_i,
    .cfg_o(cfg), .restart_o(restart)
  );

  sclk_pre_div #(.FW(FW)) i_pre (
    .clk_i, .rst_ni, .restart_i(restart), .limit_i(cfg.pre),
    .cnt_o(pre_cnt), .tick_o(pre_tick)
  );

  sclk_post_div #(.FW(FW), .CW(PCW)) i_post (
    .clk_i, .rst_ni, .restart_i(restart), .tick_i(pre_tick),
    .shift_i(cfg.post), .roll_o(roll)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      step_q <= 1'b0;
      sclk_q <= 1'b0;
    end else if (restart) begin
      step_q <= 1'b0;
      sclk_q <= 1'b0;
    end else begin
      step_q <= roll;
      sclk_q <= sclk_q ^ roll;
    end
  end

  assign step_o = step_q;
  assign sclk_o = sclk_q;
endmodule

// File: rtl/sclk_div_checker.sv
module sclk_div_checker
  import sclk_div_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               step_o,
  input logic               sclk_o,
  input logic               restart,
  input div_cfg_t           cfg,
  input logic [FIELD_W-1:0] pre_cnt
);
  logic past_ok;
  logic cfg_zero;

  assign cfg_zero = (cfg.pre == '0) && (cfg.post == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  assert_pre_in_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_cnt <= cfg.pre);

  assert_single_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_o && !cfg_zero) |=> !step_o);

  assert_sclk_flips_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && step_o) |-> (sclk_o != $past(sclk_o)));

  assert_sclk_holds_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && !step_o && !$past(restart)) |-> $stable(sclk_o));

  assert_every_cycle_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restart && cfg_zero) |=> step_o);

  assert_restart_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart |=> (!step_o && !sclk_o));
endmodule

bind sclk_divider sclk_div_checker i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .step_o(step_o), .sclk_o(sclk_o),
  .restart(restart), .cfg(cfg), .pre_cnt(pre_cnt)
);

// File: tb/test_sclk_divider.sv
module test_sclk_divider;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] ctrl_i = 16'h0000;
  logic        step_o, sclk_o;

  int    n_checks = 0;
  int    n_bad = 0;
  string cur_tag = "R1";
  bit    done = 1'b0;

  // behavioural reference state
  int m_pre = 0, m_post = 0, ph = 0;
  bit m_en = 1'b0, m_sclk = 1'b0;

  sclk_divider i_sclk_divider (.clk_i, .rst_ni, .ctrl_i, .step_o, .sclk_o);

  always #4 clk_i = ~clk_i;

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_pre = 0; m_post = 0; ph = 0; m_en = 0; m_sclk = 0;
    end else begin
      int np, nq, per;
      np = ctrl_i[15:12];
      nq = ctrl_i[11:8];
      if (np != m_pre || nq != m_post) begin
        m_pre = np; m_post = nq; ph = 0; m_en = 0; m_sclk = 0;
      end else begin
        per  = (m_pre + 1) << m_post;
        m_en = ((ph % per) == per - 1);
        if (m_en) m_sclk = !m_sclk;
        ph++;
      end
    end
  end

  task automatic check(string tag, logic act_en, logic act_sc, bit exp_en, bit exp_sc);
    n_checks++;
    if (act_en !== exp_en || act_sc !== exp_sc) begin
      n_bad++;
      $display("FAIL %s step=%b/%b sclk=%b/%b (actual/expected) t=%0t",
               tag, act_en, exp_en, act_sc, exp_sc, $time);
    end
  endtask

  task automatic run(int cycles);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk_i);
      check(cur_tag, step_o, sclk_o, m_en, m_sclk);
    end
  endtask

  task automatic apply(string tag, logic [15:0] word, int cycles);
    cur_tag = tag;
    ctrl_i  = word;
    run(cycles);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    check("R1", step_o, sclk_o, 1'b0, 1'b0);
    ctrl_i = 16'h3300;  // fields changing in reset must be ignored
    @(negedge clk_i);
    check("R1", step_o, sclk_o, 1'b0, 1'b0);
    ctrl_i = 16'h0000;
    @(negedge clk_i);
    rst_ni = 1'b1;

    apply("R6", 16'h0000, 20);
    apply("R2", 16'h3000, 40);
    apply("R3", 16'h0300, 40);
    apply("R4", 16'h2200, 60);
    apply("R9", 16'h22A5, 30);
    apply("R9", 16'h225A, 30);
    apply("R5", 16'hF100, 100);
    apply("R7", 16'hF300, 70);
    apply("R7", 16'h5300, 70);

    // restart landing on the edge where a pulse is due (period 4)
    apply("R8", 16'h1100, 9);
    while ((ph % 4) != 3) run(1);
    apply("R8", 16'h1200, 30);
    while ((ph % 8) != 7) run(1);
    apply("R8", 16'h0000, 10);

    apply("R10", 16'h0F00, 70000);
    apply("R6", 16'h00FF, 10);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_checks, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_bad++;
      $display("FAIL watchdog %s expired", cur_tag);
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end
endmodule